// File: doc/BRIEF.md
# Multi-Register Stack Transfer Sequencer

This block turns one block-transfer command into a series of single-word memory accesses. A command carries a 16-bit register bitmap, a base address, a stack discipline, a load/store bit and a writeback request. The sequencer walks the bitmap from the lowest set bit to the highest. For each selected register it issues one word request carrying the address and the register index. Registers always sit in ascending memory order: the lowest-numbered register goes to the lowest address, and words are four bytes apart. The stack discipline and the transfer direction only decide where that run of words starts.

The stack discipline has two independent choices. A full stack has its pointer on the most recent item, while an empty stack has it on the next free slot. An ascending stack grows toward higher addresses and a descending stack toward lower ones. A store is a push, so it moves the pointer in the growth direction. A load is a pop, so it moves the pointer the other way. When every beat has been accepted, a one-cycle done pulse presents the resulting base: the moved pointer if writeback was asked for, otherwise the unchanged base.

The request side is a valid/ready stream. A beat is transferred on a rising clock edge where both `req_valid` and `req_ready` are high. While `req_ready` is low, the sequencer holds the beat unchanged and does not advance. `req_ready` may be held low for any number of cycles. The command inputs and `done` are plain control pins.

Top module: `stack_xfer_seq`

## Requirements
- R1: After reset the block is idle: `req_valid` and `done` are low until a command is accepted.
- R2: Each set bit of the register list produces exactly one accepted beat, in increasing bit order. `req_idx` equals that bit number, and `req_write` is 1 for a store (`start_load`=0) and 0 for a load.
- R3: Each accepted beat after the first has an address 4 higher than the one before it.
- R4: The first address depends on `start_mode` (bit 1 = full, bit 0 = ascending), the load bit, base B and set-bit count n, as follows:
  - store full-descending: B-4n
  - store empty-descending: B-4n+4
  - store full-ascending: B+4
  - store empty-ascending: B
  - load full-descending: B
  - load empty-descending: B+4
  - load full-ascending: B-4n+4
  - load empty-ascending: B-4n
- R5: While `req_valid` is high and `req_ready` is low, the beat stays valid and keeps its address, index and direction on the next cycle.
- R6: In the cycle after the last beat is accepted, `done` is high for exactly one cycle, and no request is valid while it is high.
- R7: With `start_wb`=1, `done_base` is B+4n for a store to an ascending stack or a load from a descending stack, and B-4n in the other two cases. With `start_wb`=0, `done_base` is B.
- R8: An all-zero register list issues no request and raises `done` in the cycle after the command, with `done_base` = B.
- R9: A `start` pulse that arrives while a command is still in progress is ignored and does not change the running transfer.
- R10: For a non-empty list, `req_valid` rises in the cycle after the clock edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command pulse, accepted only when idle |
| start_list | input | NREG | Register bitmap, bit i selects register i |
| start_base | input | ADDR_W | Stack pointer / base address |
| start_mode | input | 2 | Bit 1: full (1) or empty (0); bit 0: ascending (1) or descending (0) |
| start_load | input | 1 | 1 = load (pop), 0 = store (push) |
| start_wb | input | 1 | 1 = report moved base at done |
| req_valid | output | 1 | Memory beat valid |
| req_ready | input | 1 | Memory accepts the beat this cycle |
| req_addr | output | ADDR_W | Word byte address of the beat |
| req_idx | output | $clog2(NREG) | Register number of the beat |
| req_write | output | 1 | 1 = write memory, 0 = read memory |
| done | output | 1 | One-cycle completion pulse |
| done_base | output | ADDR_W | Final base value, valid with done |

## Verification
The bench uses the default parameters: sixteen list bits, 32-bit addresses and 4-byte words. With these defaults the full sixteen-register list is reachable, and so are address spans that cross a 4-KiB boundary downward. All eight combinations of stack discipline and direction run on the same sparse list. While they run, `req_ready` is dropped every third cycle, so each combination also sees held beats. Separate tests cover the top and bottom list bits together, the empty list, writeback switched off, and a start pulse that arrives during a stall.

// File: rtl/stack_xfer_pkg.sv
package stack_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  localparam int MODE_ASC_BIT  = 0;
  localparam int MODE_FULL_BIT = 1;

endpackage

// File: rtl/stack_xfer_popcount.sv
module stack_xfer_popcount #(
  parameter int NREG  = 16,
  parameter int CNT_W = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0]  bits,
  output logic [CNT_W-1:0] count
);

  always_comb begin
    count = '0;
    for (int i = 0; i < NREG; i++) begin
      count = count + CNT_W'(bits[i]);
    end
  end

endmodule

// File: rtl/stack_xfer_lowbit.sv
module stack_xfer_lowbit #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  bits,
  output logic [IDX_W-1:0] idx
);

  // Highest priority goes to bit 0, so scan from the top down and let lower bits overwrite.
  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (bits[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/stack_xfer_addr_plan.sv
module stack_xfer_addr_plan
  import stack_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 5
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        mode,
  input  logic              is_load,
  input  logic              wb,
  input  logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] final_base
);

  localparam int          WORD_SHIFT = $clog2(WORD_BYTES);
  localparam [ADDR_W-1:0] STEP       = ADDR_W'(WORD_BYTES);

  logic              asc, full;
  logic              walk_up;   // pointer moves toward higher addresses
  logic              pre_step;  // first word sits one step past the pointer
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] moved;

  always_comb begin
    asc      = mode[MODE_ASC_BIT];
    full     = mode[MODE_FULL_BIT];
    // A push moves with the growth direction and a pop moves against it.
    walk_up  = is_load ? ~asc : asc;
    // A push into a full stack steps before writing; a pop from an empty stack steps before reading.
    pre_step = full ^ is_load;
    span     = ADDR_W'(count) << WORD_SHIFT;
    if (walk_up) begin
      first_addr = base + (pre_step ? STEP : '0);
      moved      = base + span;
    end else begin
      first_addr = base - span + (pre_step ? '0 : STEP);
      moved      = base - span;
    end
    final_base = wb ? moved : base;
  end

endmodule

// File: rtl/stack_xfer_seq.sv
module stack_xfer_seq
  import stack_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NREG-1:0]           start_list,
  input  logic [ADDR_W-1:0]         start_base,
  input  logic [1:0]                start_mode,
  input  logic                      start_load,
  input  logic                      start_wb,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [ADDR_W-1:0]         req_addr,
  output logic [$clog2(NREG)-1:0]   req_idx,
  output logic                      req_write,
  output logic                      done,
  output logic [ADDR_W-1:0]         done_base
);

  localparam int          IDX_W = $clog2(NREG);
  localparam int          CNT_W = $clog2(NREG + 1);
  localparam [ADDR_W-1:0] STEP  = ADDR_W'(WORD_BYTES);

  seq_state_e        state_q;
  logic [NREG-1:0]   rem_q;
  logic [NREG-1:0]   rem_next;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] fin_q;
  logic              write_q;

  logic [CNT_W-1:0]  cmd_count;
  logic [ADDR_W-1:0] plan_first;
  logic [ADDR_W-1:0] plan_final;
  logic [IDX_W-1:0]  cur_idx;

  stack_xfer_popcount #(.NREG(NREG), .CNT_W(CNT_W)) u_count (
    .bits  (start_list),
    .count (cmd_count)
  );

  stack_xfer_addr_plan #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)) u_plan (
    .base       (start_base),
    .mode       (start_mode),
    .is_load    (start_load),
    .wb         (start_wb),
    .count      (cmd_count),
    .first_addr (plan_first),
    .final_base (plan_final)
  );

  stack_xfer_lowbit #(.NREG(NREG), .IDX_W(IDX_W)) u_low (
    .bits (rem_q),
    .idx  (cur_idx)
  );

  // Clearing the lowest set bit moves the walk to the next selected register.
  assign rem_next = rem_q & (rem_q - NREG'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      fin_q   <= '0;
      write_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            rem_q   <= start_list;
            addr_q  <= plan_first;
            fin_q   <= plan_final;
            write_q <= ~start_load;
            state_q <= (|start_list) ? ST_XFER : ST_DONE;
          end
        end
        ST_XFER: begin
          if (req_ready) begin
            rem_q  <= rem_next;
            addr_q <= addr_q + STEP;
            if (rem_next == '0) state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid = (state_q == ST_XFER);
  assign req_addr  = addr_q;
  assign req_idx   = cur_idx;
  assign req_write = write_q;
  assign done      = (state_q == ST_DONE);
  assign done_base = fin_q;

endmodule

// File: rtl/stack_xfer_seq_chk.sv
module stack_xfer_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 4,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [IDX_W-1:0]  req_idx,
  input logic              req_write,
  input logic              done
);

  localparam [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  a_r5_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_idx) && $stable(req_write));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid || (req_addr == $past(req_addr) + STEP));

  a_r2_idx_rises: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid || (req_idx > $past(req_idx)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  a_r2_dir_steady: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid || $stable(req_write));

endmodule

bind stack_xfer_seq stack_xfer_seq_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_idx(req_idx), .req_write(req_write), .done(done)
);

// File: tb/test_stack_xfer_seq.sv
module test_stack_xfer_seq;

  typedef struct packed {
    logic [15:0] list;
    logic [31:0] base;
    logic [1:0]  mode;
    logic        ld;
    logic        wb;
    logic [31:0] first;
    logic [31:0] fin;
  } vec_t;

  // mode: bit1 full, bit0 ascending
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h00A5, 32'h1000, 2'b10, 1'b0, 1'b1, 32'h0FF0, 32'h0FF0},
    '{16'h00A5, 32'h1000, 2'b10, 1'b1, 1'b1, 32'h1000, 32'h1010},
    '{16'h00A5, 32'h1000, 2'b00, 1'b0, 1'b1, 32'h0FF4, 32'h0FF0},
    '{16'h00A5, 32'h1000, 2'b00, 1'b1, 1'b1, 32'h1004, 32'h1010},
    '{16'h00A5, 32'h1000, 2'b11, 1'b0, 1'b1, 32'h1004, 32'h1010},
    '{16'h00A5, 32'h1000, 2'b11, 1'b1, 1'b1, 32'h0FF4, 32'h0FF0},
    '{16'h00A5, 32'h1000, 2'b01, 1'b0, 1'b1, 32'h1000, 32'h1010},
    '{16'h00A5, 32'h1000, 2'b01, 1'b1, 1'b1, 32'h0FF0, 32'h0FF0},
    '{16'h8001, 32'h2000, 2'b10, 1'b0, 1'b0, 32'h1FF8, 32'h2000},
    '{16'hFFFF, 32'h3000, 2'b01, 1'b1, 1'b1, 32'h2FC0, 32'h2FC0},
    '{16'h0000, 32'h4000, 2'b10, 1'b0, 1'b1, 32'h0000, 32'h4000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_list = '0;
  logic [31:0] start_base = '0;
  logic [1:0]  start_mode = '0;
  logic        start_load = 1'b0;
  logic        start_wb = 1'b0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [3:0]  req_idx;
  logic        req_write;
  logic        done;
  logic [31:0] done_base;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  stack_xfer_seq i_stack_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_list(start_list),
    .start_base(start_base), .start_mode(start_mode), .start_load(start_load),
    .start_wb(start_wb), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_idx(req_idx), .req_write(req_write),
    .done(done), .done_base(done_base)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_cmd(input vec_t v);
    start_list = v.list; start_base = v.base; start_mode = v.mode;
    start_load = v.ld;   start_wb = v.wb;     start = 1'b1;
  endtask

  // Walk one transfer: accept beats with a stalling ready pattern, check each beat and the done result.
  task automatic collect(input vec_t v);
    logic [15:0] rem;
    int beats;
    int cyc;
    logic [31:0] exp_addr;
    int exp_idx;
    rem = v.list; beats = 0; cyc = 0; exp_addr = v.first;
    if (v.list != 0) check(req_valid === 1'b1, "R10 valid after start", {31'd0, req_valid}, 32'd1);
    else begin
      check(done === 1'b1, "R8 done after empty command", {31'd0, done}, 32'd1);
      check(req_valid === 1'b0, "R8 no request", {31'd0, req_valid}, 32'd0);
    end
    while (done !== 1'b1 && cyc < 200) begin
      req_ready = ((cyc % 3) != 2);
      if (req_valid && req_ready) begin
        exp_idx = 0;
        for (int i = 15; i >= 0; i--) if (rem[i]) exp_idx = i;
        check(req_idx == 4'(exp_idx), "R2 register index", {28'd0, req_idx}, exp_idx);
        check(req_write == ~v.ld, "R2 direction", {31'd0, req_write}, {31'd0, ~v.ld});
        check(req_addr == exp_addr, beats == 0 ? "R4 first address" : "R3 next address", req_addr, exp_addr);
        rem[exp_idx] = 1'b0;
        exp_addr = exp_addr + 32'd4;
        beats++;
      end
      @(negedge clk);
      cyc++;
    end
    req_ready = 1'b0;
    check(beats == $countones(v.list), "R2 beat count", beats, $countones(v.list));
    check(done === 1'b1 && req_valid === 1'b0, "R6 done without request", {31'd0, done}, 32'd1);
    check(done_base == v.fin, "R7 final base", done_base, v.fin);
    @(negedge clk);
    check(done === 1'b0, "R6 done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    vec_t bv;
    repeat (3) @(negedge clk);
    check(req_valid === 1'b0 && done === 1'b0, "R1 reset idle", {30'd0, req_valid, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_valid === 1'b0 && done === 1'b0, "R1 idle after reset", {30'd0, req_valid, done}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      drive_cmd(VECS[k]);
      @(negedge clk);
      start = 1'b0;
      collect(VECS[k]);
    end

    // R5: held beat under back-pressure
    drive_cmd('{16'h0030, 32'h6000, 2'b01, 1'b0, 1'b1, 32'h6000, 32'h6008});
    @(negedge clk);
    start = 1'b0;
    req_ready = 1'b0;
    @(negedge clk);
    check(req_valid === 1'b1 && req_addr == 32'h6000 && req_idx == 4'd4, "R5 beat held",
          req_addr, 32'h6000);
    @(negedge clk);
    check(req_valid === 1'b1 && req_idx == 4'd4, "R5 index held", {28'd0, req_idx}, 32'd4);
    collect('{16'h0030, 32'h6000, 2'b01, 1'b0, 1'b1, 32'h6000, 32'h6008});

    // R9: start while busy is ignored
    bv = '{16'h0003, 32'h5000, 2'b01, 1'b0, 1'b1, 32'h5000, 32'h5008};
    drive_cmd(bv);
    @(negedge clk);
    start = 1'b0;
    req_ready = 1'b0;
    drive_cmd('{16'hF000, 32'h9000, 2'b10, 1'b1, 1'b1, 32'h0, 32'h0});
    @(negedge clk);
    start = 1'b0;
    check(req_addr == 32'h5000, "R9 busy start ignored", req_addr, 32'h5000);
    collect(bv);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule